// File: doc/BRIEF.md
# Refresh-Aware Memory Access Arbiter

This block shares one memory port among several buffer channels and keeps the memory refreshed on time. Each channel holds a request line high and reports how full its buffer is. When the port is free, the arbiter picks one requesting channel and sends it a one-cycle begin-access strobe. It then keeps that channel's grant until the channel returns its end-access strobe. A configuration input selects the winner rule. The rule is either rotating order or largest fill level first.

A timer counts cycles since the last refresh began. When the timer reaches the safe threshold (refresh interval minus a margin), the next free slot goes to a refresh. A refresh holds the memory for a fixed number of cycles, and no channel is granted during it. An access in progress is never cut short. Instead, the refresh begins right after that access ends. If the timer reaches the hard limit (refresh interval plus refresh length), a sticky error flag is raised.

With the default parameters, one cycle is 5 ns. The refresh interval is 3125 cycles, a refresh lasts 20 cycles, and the margin is 6 cycles. Reset is synchronous and active-high.

Top module: `mem_refresh_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ch_grant`, `ch_start`, `refresh_busy` and `deadline_err` are all zero. The first rotating-order search after reset starts at channel 0.
- R2: At most one bit of `ch_grant` is set at any time. A grant begins with a one-cycle `ch_start` pulse on the same channel, in the same cycle that the grant bit rises.
- R3: A grant stays on its channel until that channel's own `ch_done` bit is seen. A `ch_done` bit from any other channel has no effect.
- R4: When `policy_fullest` is 0, the winner is the first requesting channel found by counting upward, with wrap-around, from the channel after the most recently granted one (under either policy). Channels that are not requesting are skipped.
- R5: When `policy_fullest` is 1, the winner is the requesting channel with the largest `ch_fill` field. The field for channel i is bits [i*FILL_W +: FILL_W]. On a tie, the lowest index wins.
- R6: When the timer has reached the safe threshold while the port is free, a refresh starts instead of a grant, even if requests are pending. Starting a refresh resets the timer to zero. With no traffic, one refresh starts every REFRESH_INTERVAL-SAFE_MARGIN+1 cycles.
- R7: `refresh_busy` is high for exactly REFRESH_LEN consecutive cycles per refresh, and `ch_grant` is zero throughout.
- R8: A refresh never starts while a grant is held. If the threshold has passed during an access, `refresh_busy` rises in the cycle after the owner's `ch_done` is sampled.
- R9: `deadline_err` goes high once the timer reaches REFRESH_INTERVAL+REFRESH_LEN. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_fullest | input | 1 | 0 = rotating order, 1 = fullest buffer first |
| ch_req | input | NUM_CH | Per-channel access request |
| ch_fill | input | NUM_CH*FILL_W | Packed per-channel fill levels |
| ch_done | input | NUM_CH | Per-channel end-access strobe |
| ch_start | output | NUM_CH | One-cycle begin-access strobe |
| ch_grant | output | NUM_CH | One-hot grant, held for the whole access |
| refresh_busy | output | 1 | High while a refresh occupies the memory |
| deadline_err | output | 1 | Sticky flag: refresh deadline missed |

## Verification
Two functions can fall in the same cycle. The first is the refresh threshold being reached. The second is either a channel's end-access strobe or a fresh request. The bench provokes this with continuous requests from every channel during a long grant sweep, so refreshes keep landing between grants. It also holds one access past the threshold and then releases it. The judgement covers three points: no grant is issued while `refresh_busy` is high, each refresh lasts exactly its length, and the refresh follows the released access in the very next cycle rather than losing the slot to a waiting channel.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_REFRESH = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_CH = 9,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [IDX_W-1:0]  last,
  output logic              found,
  output logic [IDX_W-1:0]  pick
);
  int unsigned idx;

  // Scan upward from the channel after the last winner, wrapping around.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = (int'(last) + k) % NUM_CH;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/arb_fill_pick.sv
module arb_fill_pick #(
  parameter int NUM_CH = 9,
  parameter int FILL_W = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*FILL_W-1:0] fill,
  output logic                     found,
  output logic [IDX_W-1:0]         pick
);
  logic [FILL_W-1:0] best;

  // A strict comparison keeps the lower index when two fill levels are equal.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (!found || fill[i*FILL_W +: FILL_W] > best)) begin
        found = 1'b1;
        pick  = IDX_W'(i);
        best  = fill[i*FILL_W +: FILL_W];
      end
    end
  end
endmodule

// File: rtl/arb_refresh_timer.sv
module arb_refresh_timer #(
  parameter int REFRESH_INTERVAL = 3125,
  parameter int REFRESH_LEN      = 20,
  parameter int SAFE_MARGIN      = 6,
  localparam int SAFE_AT  = REFRESH_INTERVAL - SAFE_MARGIN,
  localparam int HARD_AT  = REFRESH_INTERVAL + REFRESH_LEN,
  localparam int CNT_W    = $clog2(HARD_AT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic at_safe,
  output logic at_hard
);
  logic [CNT_W-1:0] cnt;

  // Counts cycles since the last refresh start and saturates at the hard limit.
  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (restart)               cnt <= '0;
    else if (cnt != CNT_W'(HARD_AT)) cnt <= cnt + 1'b1;
  end

  assign at_safe = (cnt >= CNT_W'(SAFE_AT));
  assign at_hard = (cnt == CNT_W'(HARD_AT));
endmodule

// File: rtl/mem_refresh_arbiter.sv
module mem_refresh_arbiter #(
  parameter int NUM_CH           = 9,
  parameter int FILL_W           = 8,
  parameter int REFRESH_INTERVAL = 3125,
  parameter int REFRESH_LEN      = 20,
  parameter int SAFE_MARGIN      = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     policy_fullest,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic [NUM_CH*FILL_W-1:0] ch_fill,
  input  logic [NUM_CH-1:0]        ch_done,
  output logic [NUM_CH-1:0]        ch_start,
  output logic [NUM_CH-1:0]        ch_grant,
  output logic                     refresh_busy,
  output logic                     deadline_err
);
  import arb_pkg::*;

  localparam int IDX_W = $clog2(NUM_CH);
  localparam int LEN_W = $clog2(REFRESH_LEN + 1);

  arb_state_e       state;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] last_win;
  logic [LEN_W-1:0] ref_left;

  logic             rr_found, fill_found, any_found;
  logic [IDX_W-1:0] rr_pick, fill_pick, win;
  logic             at_safe, at_hard, owner_done, restart;

  arb_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
    .req   (ch_req),
    .last  (last_win),
    .found (rr_found),
    .pick  (rr_pick)
  );

  arb_fill_pick #(.NUM_CH(NUM_CH), .FILL_W(FILL_W)) u_fill (
    .req   (ch_req),
    .fill  (ch_fill),
    .found (fill_found),
    .pick  (fill_pick)
  );

  arb_refresh_timer #(
    .REFRESH_INTERVAL (REFRESH_INTERVAL),
    .REFRESH_LEN      (REFRESH_LEN),
    .SAFE_MARGIN      (SAFE_MARGIN)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .at_safe (at_safe),
    .at_hard (at_hard)
  );

  assign any_found  = policy_fullest ? fill_found : rr_found;
  assign win        = policy_fullest ? fill_pick  : rr_pick;
  assign owner_done = ch_done[owner];

  // A refresh begins from a free port, or straight after the owner releases.
  assign restart = at_safe &&
                   ((state == ST_IDLE) || (state == ST_ACCESS && owner_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      owner        <= '0;
      last_win     <= IDX_W'(NUM_CH - 1);
      ref_left     <= '0;
      ch_start     <= '0;
      deadline_err <= 1'b0;
    end else begin
      ch_start     <= '0;
      deadline_err <= deadline_err | at_hard;
      unique case (state)
        ST_IDLE: begin
          if (at_safe) begin
            state    <= ST_REFRESH;
            ref_left <= LEN_W'(REFRESH_LEN - 1);
          end else if (any_found) begin
            state    <= ST_ACCESS;
            owner    <= win;
            last_win <= win;
            ch_start <= NUM_CH'(1) << win;
          end
        end
        ST_ACCESS: begin
          if (owner_done) begin
            if (at_safe) begin
              state    <= ST_REFRESH;
              ref_left <= LEN_W'(REFRESH_LEN - 1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_REFRESH: begin
          if (ref_left == '0) state <= ST_IDLE;
          else                ref_left <= ref_left - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ch_grant     = (state == ST_ACCESS) ? (NUM_CH'(1) << owner) : '0;
  assign refresh_busy = (state == ST_REFRESH);
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_CH = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_done,
  input logic [NUM_CH-1:0] ch_start,
  input logic [NUM_CH-1:0] ch_grant,
  input logic              refresh_busy,
  input logic              deadline_err
);
  // R2: never more than one channel owns the port
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_grant));

  // R2: the begin strobe marks the owner of the new grant
  a_r2_start_matches: assert property (@(posedge clk) disable iff (rst)
    (ch_start != '0) |-> (ch_grant == ch_start));

  // R2: the begin strobe lasts a single cycle
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
    (ch_start != '0) |=> (ch_start == '0));

  // R3: the grant is kept until the owner itself signals the end
  a_r3_grant_held: assert property (@(posedge clk) disable iff (rst)
    (ch_grant != '0 && (ch_grant & ch_done) == '0) |=> (ch_grant == $past(ch_grant)));

  // R7: no channel owns the port during a refresh
  a_r7_no_grant_refresh: assert property (@(posedge clk) disable iff (rst)
    refresh_busy |-> (ch_grant == '0));

  // R8: an access that is not ending cannot be followed by a refresh
  a_r8_no_preempt: assert property (@(posedge clk) disable iff (rst)
    (ch_grant != '0 && (ch_grant & ch_done) == '0) |=> !refresh_busy);

  // R9: the deadline flag stays set
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    deadline_err |=> deadline_err);
endmodule

bind mem_refresh_arbiter arb_checker #(.NUM_CH(NUM_CH)) u_arb_checker (
  .clk          (clk),
  .rst          (rst),
  .ch_done      (ch_done),
  .ch_start     (ch_start),
  .ch_grant     (ch_grant),
  .refresh_busy (refresh_busy),
  .deadline_err (deadline_err)
);

// File: tb/mem_refresh_arbiter_tb.sv
module mem_refresh_arbiter_tb;
  localparam int N        = 9;
  localparam int FW       = 4;
  localparam int INTERVAL = 40;
  localparam int RLEN     = 4;
  localparam int MARGIN   = 6;
  localparam int SAFE     = INTERVAL - MARGIN;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          policy_fullest = 1'b0;
  logic [N-1:0]  ch_req  = '0;
  logic [N*FW-1:0] ch_fill = '0;
  logic [N-1:0]  ch_done = '0;
  logic [N-1:0]  ch_start, ch_grant;
  logic          refresh_busy, deadline_err;

  int checks = 0;
  int errors = 0;
  int last   = N - 1;
  int fills[N];
  bit finished = 0;

  int run_len = 0, ref_count = 0, bad_len = 0, grant_in_ref = 0;

  always #10 clk = ~clk;

  mem_refresh_arbiter #(
    .NUM_CH(N), .FILL_W(FW), .REFRESH_INTERVAL(INTERVAL),
    .REFRESH_LEN(RLEN), .SAFE_MARGIN(MARGIN)
  ) u_dut (
    .clk(clk), .rst(rst), .policy_fullest(policy_fullest),
    .ch_req(ch_req), .ch_fill(ch_fill), .ch_done(ch_done),
    .ch_start(ch_start), .ch_grant(ch_grant),
    .refresh_busy(refresh_busy), .deadline_err(deadline_err)
  );

  // Refresh monitor for R6/R7
  always @(negedge clk) begin
    if (rst) run_len = 0;
    else begin
      if (refresh_busy && ch_grant != '0) grant_in_ref++;
      if (refresh_busy) run_len++;
      else if (run_len > 0) begin
        if (run_len != RLEN) bad_len++;
        ref_count++;
        run_len = 0;
      end
    end
  end

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int onehot_idx(logic [N-1:0] v);
    int r = -1;
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) begin r = i; c++; end
    return (c == 1) ? r : -1;
  endfunction

  function automatic int rr_expect(int lst, logic [N-1:0] m);
    for (int k = 1; k <= N; k++) if (m[(lst + k) % N]) return (lst + k) % N;
    return -1;
  endfunction

  function automatic int fill_expect(logic [N-1:0] m);
    int b = -1;
    for (int i = 0; i < N; i++) if (m[i] && (b < 0 || fills[i] > fills[b])) b = i;
    return b;
  endfunction

  task automatic load_fills();
    for (int i = 0; i < N; i++) ch_fill[i*FW +: FW] = FW'(fills[i]);
  endtask

  task automatic wait_start(string tag, output int idx);
    int t = 0;
    idx = -1;
    while (ch_start == '0 && t < 300) begin @(negedge clk); t++; end
    if (ch_start == '0) check_eq(tag, "begin strobe timeout", 0, 1);
    else begin
      idx = onehot_idx(ch_start);
      check_eq("R2", "grant equals begin strobe", int'(ch_grant), int'(ch_start));
      last = idx;
    end
  endtask

  task automatic grant_cycle(string tag, output int idx);
    wait_start(tag, idx);
    if (idx >= 0) ch_done[idx] = 1'b1;
    @(negedge clk);
    ch_done = '0;
  endtask

  task automatic wait_busy_fall();
    int t = 0;
    while (!refresh_busy && t < 300) begin @(negedge clk); t++; end
    while (refresh_busy && t < 300) begin @(negedge clk); t++; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    int idx, exp, n, flag;
    repeat (3) @(negedge clk);
    check_eq("R1", "grant during reset", int'(ch_grant), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "grant after reset", int'(ch_grant), 0);
    check_eq("R1", "start after reset", int'(ch_start), 0);
    check_eq("R1", "busy after reset", int'(refresh_busy), 0);
    check_eq("R1", "err after reset", int'(deadline_err), 0);

    // R1: first rotating grant goes to channel 0
    ch_req = '1;
    grant_cycle("R1", idx);
    check_eq("R1", "first grant", idx, 0);

    // R4: sweep every nonzero request mask
    for (int m = 1; m < (1 << N); m++) begin
      ch_req = N'(m);
      exp = rr_expect(last, N'(m));
      grant_cycle("R4", idx);
      check_eq("R4", $sformatf("rr pick mask %0h", m), idx, exp);
    end
    check_eq("R6", "refresh happened under load", int'(ref_count > 0), 1);
    check_eq("R7", "refresh length violations", bad_len, 0);
    check_eq("R7", "grants during refresh", grant_in_ref, 0);

    // R5: fullest-first patterns
    policy_fullest = 1'b1;
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < N; i++) begin
        if (p == 6)      fills[i] = (i % 3) * 5;
        else if (p == 7) fills[i] = 9;
        else             fills[i] = (i * 5 + p * 7) % 16;
      end
      load_fills();
      ch_req = (p % 2 == 1 && p != 7) ? N'(9'h1AA) : '1;
      exp = fill_expect(ch_req);
      grant_cycle("R5", idx);
      check_eq("R5", $sformatf("fullest pick pattern %0d", p), idx, exp);
    end
    policy_fullest = 1'b0;

    // R3: a foreign end strobe is ignored
    ch_req = '1;
    wait_start("R3", idx);
    ch_done[(idx + 1) % N] = 1'b1;
    @(negedge clk);
    ch_done = '0;
    flag = 0;
    for (int c = 0; c < 3; c++) begin
      if (ch_grant != (N'(1) << idx) || ch_start != '0) flag++;
      @(negedge clk);
    end
    check_eq("R3", "grant kept after foreign end", flag, 0);
    ch_done[idx] = 1'b1;
    @(negedge clk);
    ch_done = '0;
    check_eq("R3", "grant released by owner", int'(ch_grant), 0);

    // R6: idle refresh period
    ch_req = '0;
    wait_busy_fall();
    while (!refresh_busy) @(negedge clk);
    n = 0;
    while (refresh_busy) begin @(negedge clk); n++; end
    while (!refresh_busy && n < 300) begin @(negedge clk); n++; end
    check_eq("R6", "idle refresh period", n, SAFE + 1);

    // R8: refresh deferred until the access ends
    wait_busy_fall();
    ch_req = N'(1) << 3;
    wait_start("R8", idx);
    check_eq("R8", "owner", idx, 3);
    flag = 0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      if (refresh_busy) flag++;
    end
    check_eq("R8", "refresh during access", flag, 0);
    ch_done[3] = 1'b1;
    @(negedge clk);
    ch_done = '0;
    check_eq("R8", "refresh right after end", int'(refresh_busy), 1);
    check_eq("R8", "no grant at refresh", int'(ch_grant), 0);
    check_eq("R9", "no error within limit", int'(deadline_err), 0);

    // R9: deadline missed by a long access
    wait_busy_fall();
    wait_start("R9", idx);
    repeat (60) @(negedge clk);
    check_eq("R9", "error after overlong access", int'(deadline_err), 1);
    ch_done[idx] = 1'b1;
    @(negedge clk);
    ch_done = '0;
    ch_req = '0;
    repeat (40) @(negedge clk);
    check_eq("R9", "error sticky", int'(deadline_err), 1);

    // R1: reset clears the flag and restarts rotation at channel 0
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    last = N - 1;
    @(negedge clk);
    check_eq("R1", "err after second reset", int'(deadline_err), 0);
    check_eq("R1", "grant after second reset", int'(ch_grant), 0);
    ch_req = '1;
    grant_cycle("R1", idx);
    check_eq("R1", "first grant after second reset", idx, 0);

    finish_run();
  end
endmodule